// File: doc/BRIEF.md
# Dual-Clock Frame Buffer Pointer Controller

This block is a small frame store with a write port and a read port, each running on its own clock. The two ports share one synchronous memory. Each port owns an address pointer. The pointer steps by one word on every enabled clock edge. A clear command sends it back to word zero. A set command jumps it to any address taken from a 24-bit address bus, and only the low address bits that the memory decodes are used. Clear and set are edge-triggered. Two polarity inputs choose whether each command fires on a falling or a rising transition of its line.

The write port stores a 12-bit word at the address chosen on the same edge, so a command and its first data word go in together. The read port feeds memory words through a delay line. A read clear delivers word zero after 9 enabled edges, and a read jump delivers the target word after 14 enabled edges. A valid flag stays low while the delay line refills. An active-low output enable floats the data bus.

Top module: `fb_pointer_ctrl`

## Requirements
- R1: A set command uses only the low MEM_AW bits of the 24-bit address bus (six bits, 64 words, by default). The upper bits have no effect.
- R2: On the write-clock edge that detects a write clear, with wen_n low, the word on din is stored at address 0. The next enabled write goes to address 1.
- R3: On the write-clock edge that detects a write set, with wen_n low, the word on din is stored at the bus address. Later writes follow from that address.
- R4: On an edge with wen_n low and no command, the write pointer steps by one and wraps from the last word to 0. With wen_n high, nothing is written and the pointer holds.
- R5: A read clear is counted from the edge that detects it, which is enabled edge 1. dvalid stays low through enabled edge 8. After enabled edge 9, dout carries word 0 with dvalid high.
- R6: A read set to address A is counted from the edge that detects it, which is enabled edge 1. dvalid stays low through enabled edge 13. After enabled edge 14, dout carries word A with dvalid high.
- R7: Once valid, the read port delivers consecutive addresses, one per edge with ren_n low, and wraps past the last word. An edge with ren_n high leaves dout, dvalid and the read pointer unchanged.
- R8: A polarity input of 1 makes its command fire on a 1-to-0 transition, with idle level 1. A polarity input of 0 makes it fire on a 0-to-1 transition, with idle level 0. clr_fall selects for both clear lines and set_fall for both set lines. A line held at its active level does not fire again. The polarity inputs change only during reset.
- R9: When clear and set fire on the same edge, the clear wins on either port.
- R10: With oe_n high, dout is not driven (high impedance) and dvalid is unaffected.
- R11: After reset, both pointers are 0 and dvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-side reset, active low, synchronous |
| wen_n | input | 1 | Write enable, active low |
| wclr | input | 1 | Write clear command line, edge-triggered |
| wset | input | 1 | Write set (jump) command line, edge-triggered |
| waddr | input | 24 | Jump address for the write pointer |
| din | input | 12 | Write data |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-side reset, active low, synchronous |
| ren_n | input | 1 | Read enable, active low |
| rclr | input | 1 | Read clear command line, edge-triggered |
| rset | input | 1 | Read set (jump) command line, edge-triggered |
| raddr | input | 24 | Jump address for the read pointer |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 12 | Read data, high impedance when oe_n is high |
| dvalid | output | 1 | High when dout carries a word from the current stream |
| clr_fall | input | 1 | Clear polarity: 1 selects falling transition, 0 selects rising |
| set_fall | input | 1 | Set polarity: 1 selects falling transition, 0 selects rising |

## Verification
The bench counts edges exactly after each read clear and each read jump. A design with the delay line off by one stage, or with the tap not switched between the two modes, shows the word or the valid flag one edge early or late. Command lines stay asserted for the whole burst. A level-sensitive design keeps reloading its pointer, so it repeats the first word instead of stepping. Other cases the bench covers:
- Writes that wrap past the top word: a design without the wrap loses the word that should land at address 0.
- A jump address with high bits set: a design that decodes those bits reads the wrong word.
- Clear and set fired together: a design that favours the set starts at the jump address instead of word 0.
- A read stall: a design that shifts without ren_n lets the output move during the stall.
- The rising-edge polarity mode: a design without it never takes the command.

// File: rtl/fb_pointer_ctrl.sv
module fb_pointer_ctrl #(
  parameter int DW      = 12,
  parameter int AW      = 24,
  parameter int MEM_AW  = 6,
  parameter int CLR_LAT = 9,
  parameter int JMP_LAT = 14
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen_n,
  input  logic          wclr,
  input  logic          wset,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] din,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren_n,
  input  logic          rclr,
  input  logic          rset,
  input  logic [AW-1:0] raddr,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dvalid,
  input  logic          clr_fall,
  input  logic          set_fall
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] mem [DEPTH];

  logic unused_hi;
  assign unused_hi = ^{waddr[AW-1:MEM_AW], raddr[AW-1:MEM_AW]};

  // write side
  logic [MEM_AW-1:0] wptr, wtgt;
  logic wclr_q, wset_q, wclr_ev, wset_ev;

  assign wclr_ev = clr_fall ? (wclr_q & ~wclr) : (~wclr_q & wclr);
  assign wset_ev = set_fall ? (wset_q & ~wset) : (~wset_q & wset);
  assign wtgt    = wclr_ev ? '0 : (wset_ev ? waddr[MEM_AW-1:0] : wptr);

  always_ff @(posedge wclk) begin
    if (!wrst_n) begin
      wptr   <= '0;
      wclr_q <= clr_fall;
      wset_q <= set_fall;
    end else begin
      wclr_q <= wclr;
      wset_q <= wset;
      wptr   <= wtgt + MEM_AW'(!wen_n);
    end
  end

  always_ff @(posedge wclk)
    if (wrst_n && !wen_n) mem[wtgt] <= din;

  // read side
  logic [MEM_AW-1:0] rptr, rtgt;
  logic rclr_q, rset_q, rclr_ev, rset_ev, r_ev;
  logic [DW-1:0] pipe [JMP_LAT];
  logic [JMP_LAT-1:0] pvld;
  logic jmp_mode;
  logic [DW-1:0] tap_d;

  assign rclr_ev = clr_fall ? (rclr_q & ~rclr) : (~rclr_q & rclr);
  assign rset_ev = set_fall ? (rset_q & ~rset) : (~rset_q & rset);
  assign r_ev    = rclr_ev | rset_ev;
  assign rtgt    = rclr_ev ? '0 : (rset_ev ? raddr[MEM_AW-1:0] : rptr);

  always_ff @(posedge rclk) begin
    if (!rrst_n) begin
      rptr     <= '0;
      rclr_q   <= clr_fall;
      rset_q   <= set_fall;
      pvld     <= '0;
      jmp_mode <= 1'b0;
    end else begin
      rclr_q <= rclr;
      rset_q <= rset;
      rptr   <= rtgt + MEM_AW'(!ren_n);
      if (r_ev) jmp_mode <= ~rclr_ev;
      if (!ren_n)
        pvld <= {pvld[JMP_LAT-2:0] & {(JMP_LAT-1){~r_ev}}, 1'b1};
      else if (r_ev)
        pvld <= '0;
    end
  end

  always_ff @(posedge rclk) begin
    if (!ren_n) begin
      pipe[0] <= mem[rtgt];
      for (int i = 1; i < JMP_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign tap_d  = jmp_mode ? pipe[JMP_LAT-1] : pipe[CLR_LAT-1];
  assign dvalid = jmp_mode ? pvld[JMP_LAT-1] : pvld[CLR_LAT-1];
  assign dout   = oe_n ? {DW{1'bz}} : tap_d;

  // checks
  assert_wclr_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wclr_ev && !wen_n) |=> (wptr == MEM_AW'(1)));

  assert_winc_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!wclr_ev && !wset_ev && !wen_n) |=> (wptr == $past(wptr) + MEM_AW'(1)));

  assert_flush_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_ev |=> !dvalid);

  assert_stall_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ren_n && !r_ev) |=> ($stable(dvalid) && $stable(tap_d) && $stable(rptr)));

  assert_clr_first_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rclr_ev && !ren_n) |=> (rptr == MEM_AW'(1)));
endmodule

// File: tb/tb_fb_pointer_ctrl.sv
module tb_fb_pointer_ctrl;
  logic wclk = 0, rclk = 0;
  logic wrst_n, wen_n, wclr, wset, rrst_n, ren_n, rclr, rset, oe_n;
  logic clr_fall, set_fall;
  logic [23:0] waddr, raddr;
  logic [11:0] din;
  wire  [11:0] dout;
  wire         dvalid;

  int tests = 0, fails = 0;
  logic [11:0] model [64];
  int wp = 0;
  logic idle;

  fb_pointer_ctrl dut (
    .wclk(wclk), .wrst_n(wrst_n), .wen_n(wen_n), .wclr(wclr), .wset(wset),
    .waddr(waddr), .din(din), .rclk(rclk), .rrst_n(rrst_n), .ren_n(ren_n),
    .rclr(rclr), .rset(rset), .raddr(raddr), .oe_n(oe_n), .dout(dout),
    .dvalid(dvalid), .clr_fall(clr_fall), .set_fall(set_fall)
  );

  always #10 wclk = ~wclk;
  initial begin #7; forever #10 rclk = ~rclk; end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wstep; @(posedge wclk); #3; endtask
  task automatic rstep; @(posedge rclk); #3; endtask

  task automatic do_reset(input logic pol);
    clr_fall = pol; set_fall = pol; idle = pol;
    wclr = pol; wset = pol; rclr = pol; rset = pol;
    wen_n = 1; ren_n = 1; oe_n = 0; waddr = '0; raddr = '0; din = '0;
    wrst_n = 0; rrst_n = 0;
    repeat (3) begin wstep(); rstep(); end
    wrst_n = 1; rrst_n = 1;
    wstep(); rstep();
    wp = 0;
    chk(dvalid == 1'b0, "R11 dvalid after reset", {11'd0, dvalid}, 12'd0);
  endtask

  // kind: 0 plain, 1 clear, 2 set
  task automatic wr_burst(input int kind, input logic [23:0] addr, input int n, input logic [11:0] base);
    int tgt = (kind == 1) ? 0 : (kind == 2) ? int'(addr[5:0]) : wp;
    waddr = addr;
    if (kind == 1) wclr = ~idle;
    if (kind == 2) wset = ~idle;
    for (int i = 0; i < n; i++) begin
      din = base + 12'(i); wen_n = 0;
      wstep();
      model[tgt] = base + 12'(i);
      tgt = (tgt + 1) % 64;
    end
    wen_n = 1; wclr = idle; wset = idle; din = 12'hFFF;
    repeat (3) wstep();
    wp = tgt;
  endtask

  // kind: 1 clear, 2 set, 3 both
  task automatic rd_check(input int kind, input logic [23:0] addr, input int n, input string tag);
    int lat = (kind == 2) ? 14 : 9;
    int start = (kind == 2) ? int'(addr[5:0]) : 0;
    raddr = addr;
    if (kind != 2) rclr = ~idle;
    if (kind != 1) rset = ~idle;
    ren_n = 0;
    for (int k = 1; k < lat + n; k++) begin
      rstep();
      if (k < lat)
        chk(dvalid == 1'b0, {tag, " dvalid low during fill"}, {11'd0, dvalid}, 12'd0);
      else
        chk(dvalid == 1'b1 && dout == model[(start + k - lat) % 64],
            {tag, " data"}, dout, model[(start + k - lat) % 64]);
    end
    ren_n = 1; rclr = idle; rset = idle;
    rstep();
  endtask

  task automatic stall_and_oe;
    logic [11:0] w;
    rclr = ~idle; ren_n = 0;
    repeat (9) rstep();
    chk(dvalid && dout == model[0], "R5 first word before stall", dout, model[0]);
    w = dout;
    ren_n = 1;
    for (int i = 0; i < 3; i++) begin
      rstep();
      chk(dvalid && dout == w, "R7 output frozen while ren_n high", dout, w);
    end
    oe_n = 1; #1;
    chk(dvalid == 1'b1, "R10 dvalid kept with oe_n high", {11'd0, dvalid}, 12'd1);
    chk(dout !== w, "R10 bus not driven with oe_n high", dout, w);
    oe_n = 0; #1;
    chk(dout == w, "R10 bus driven again", dout, w);
    ren_n = 0;
    rstep();
    chk(dvalid && dout == model[1], "R7 resume at next address", dout, model[1]);
    ren_n = 1; rclr = idle;
    rstep();
  endtask

  initial begin
    do_reset(1'b1);
    wr_burst(1, 24'd0, 64, 12'h100);          // R2, R4: fill and wrap back to 0
    wr_burst(2, 24'd40, 5, 12'hA00);          // R3
    wr_burst(2, 24'd62, 3, 12'hB00);          // R4 wrap: 62, 63, 0
    wr_burst(0, 24'd0, 2, 12'hC00);           // R4 plain step: 1, 2
    rd_check(1, 24'd0, 6, "R5 R2 R4 R8 clear read");
    rd_check(2, 24'd40, 5, "R6 R3 jump read");
    rd_check(2, 24'd62, 4, "R7 R4 jump read across wrap");
    rd_check(2, 24'hABC005, 2, "R1 upper address bits ignored");
    rd_check(3, 24'd40, 3, "R9 clear wins over set");
    stall_and_oe();
    do_reset(1'b0);
    wr_burst(2, 24'd10, 2, 12'hD00);          // R8 rising mode
    rd_check(1, 24'd0, 3, "R8 rising-mode clear");
    rd_check(2, 24'd10, 2, "R8 rising-mode jump");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule